// File: doc/BRIEF.md
# Banked Interrupt Enable Controller

This block gathers interrupt request lines from peripherals and local sources and merges them into one level-sensitive IRQ line for a processor. There are 64 peripheral lines, split into two banks of 32 (sources 0 to 31 and 32 to 63), and a basic bank of 8 local sources. Each line has its own enable bit. Sources 0 to 3 of the first peripheral bank are the four system timer compare matches. The basic bank carries the timer, mailbox, two doorbells, two GPU halt flags and two illegal access flags, at bit positions 0 through 7 in that order.

Software never writes an enable mask as a whole. Each bank has one set register and one clear register. Only the bits written as one change state, so a driver can enable or disable its own line without a read-modify-write and without disturbing other drivers. Pending registers show each source ANDed with its enable. The IRQ output is the OR of every pending bit. It follows the source levels directly, and the controller holds no interrupt state of its own.

Top module: `irq_enable_ctrl`

## Requirements
- R1: Reset clears all enables. While no enable is set, every pending register reads zero and `irq_out` stays low, whatever the source levels.
- R2: A write to a set offset sets the enable of each bit written as one. Bits written as zero keep their value. The set offsets are 0x210 (sources 0–31, bit k = source k), 0x214 (sources 32–63, bit k = source 32+k) and 0x218 (basic bank, bits 7:0).
- R3: A write to a clear offset clears the enable of each bit written as one. Bits written as zero keep their value. The clear offsets are 0x21C (sources 0–31), 0x220 (sources 32–63) and 0x224 (basic bank).
- R4: Offset 0x204 reads sources 0–31 ANDed with their enables. Offset 0x208 does the same for sources 32–63, and 0x200 for the basic bank in bits 7:0. The pending value tracks the source inputs in the same cycle.
- R5: `irq_out` is high exactly when at least one source is asserted while its enable is set. It changes in the same cycle as the sources, with no latching.
- R6: A read of a bank's set offset returns that bank's current enable mask. A read of its clear offset returns the same mask.
- R7: Writes to the pending offsets (0x200, 0x204, 0x208) and to unmapped offsets change no enable bit.
- R8: Bits 31:8 of a basic bank write are ignored. Bits 31:8 of every basic bank read are zero.
- R9: A read of an unmapped offset returns zero.
- R10: A set or clear write takes effect at the clock edge that samples it. In the cycle of the write, the reads and `irq_out` still show the enable state from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| periph_irq | input | 64 | Peripheral interrupt levels, bit n = source n |
| basic_irq | input | 8 | Basic bank interrupt levels |
| bus_addr | input | 12 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Combined interrupt request to the processor |

## Verification
Two functions can fall in the same cycle: an enable write, and the source level it gates. The bench raises a source line and issues the set write for that line in one cycle. It then checks that `irq_out` and the read-back mask still show the old enable until the edge. After that edge, the interrupt must appear. The reverse case also runs: a clear write for a line that is held asserted must drop `irq_out` only after the edge that samples the write.

// File: rtl/irqc_pkg.sv
// Package: shared geometry and register layout of the interrupt enable controller.
// Assumes at most three peripheral banks, so the pending offsets stay below
// the first set offset (0x210).
package irqc_pkg;

    // Default geometry
    localparam int DATA_W  = 32;
    localparam int N_PBANK = 2;
    localparam int BASIC_W = 8;
    localparam int ADDR_W  = 12;

    // Layout anchors. Everything else is derived from these and the bank count.
    localparam int OFF_PEND_BASIC = 32'h200;
    localparam int OFF_PEND_BANK0 = 32'h204;
    localparam int OFF_SET_BANK0  = 32'h210;

    // Pending offset of peripheral bank g
    function automatic int off_pend(input int g);
        return OFF_PEND_BANK0 + 4 * g;
    endfunction

    // Set offset of peripheral bank g. Index nb is the basic bank.
    function automatic int off_set(input int g);
        return OFF_SET_BANK0 + 4 * g;
    endfunction

    // Clear offset of peripheral bank g. Index nb is the basic bank.
    function automatic int off_clr(input int nb, input int g);
        return OFF_SET_BANK0 + 4 * (nb + 1) + 4 * g;
    endfunction

endpackage

// File: rtl/irqc_bank.sv
// Module: one enable bank. Holds a W-bit enable mask that changes only
// through set-one and clear-one strobes, and forms the gated pending vector.
// Assumes the register interface never asserts set_we and clr_we together.
// If it did, the set strobe would take precedence.
module irqc_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wmask,
    input  logic [W-1:0] src,
    output logic [W-1:0] en,
    output logic [W-1:0] pend
);

    // Enable mask update: OR in set bits, AND out clear bits, clear at reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en <= '0;
        end else if (set_we) begin
            en <= en | wmask;
        end else if (clr_we) begin
            en <= en & ~wmask;
        end
    end

    // Pending: the live source level gated by its enable
    always_comb begin
        pend = src & en;
    end

endmodule

// File: rtl/irqc_regif.sv
// Module: register decode for the controller. Turns the bus address and write
// strobe into per-bank set and clear strobes, and muxes enables and pending
// vectors onto the read data. Read data is combinational from the address.
// Assumes DATA_W > BASIC_W and word-aligned offsets.
module irqc_regif
    import irqc_pkg::*;
#(
    parameter int ADDR_W  = irqc_pkg::ADDR_W,
    parameter int DATA_W  = irqc_pkg::DATA_W,
    parameter int N_PBANK = irqc_pkg::N_PBANK,
    parameter int BASIC_W = irqc_pkg::BASIC_W
) (
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic                      bus_wr,
    input  logic [N_PBANK*DATA_W-1:0] en_p,
    input  logic [N_PBANK*DATA_W-1:0] pend_p,
    input  logic [BASIC_W-1:0]        en_b,
    input  logic [BASIC_W-1:0]        pend_b,
    output logic [N_PBANK-1:0]        set_we_p,
    output logic [N_PBANK-1:0]        clr_we_p,
    output logic                      set_we_b,
    output logic                      clr_we_b,
    output logic [DATA_W-1:0]         bus_rdata
);

    localparam int PAD_W = DATA_W - BASIC_W;

    // Write strobe decode: one strobe per bank and direction
    always_comb begin
        for (int g = 0; g < N_PBANK; g++) begin
            set_we_p[g] = bus_wr && (bus_addr == ADDR_W'(off_set(g)));
            clr_we_p[g] = bus_wr && (bus_addr == ADDR_W'(off_clr(N_PBANK, g)));
        end
        set_we_b = bus_wr && (bus_addr == ADDR_W'(off_set(N_PBANK)));
        clr_we_b = bus_wr && (bus_addr == ADDR_W'(off_clr(N_PBANK, N_PBANK)));
    end

    // Read mux: pending, or the enable mask behind both set and clear offsets
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFF_PEND_BASIC)) begin
            bus_rdata = {{PAD_W{1'b0}}, pend_b};
        end
        if (bus_addr == ADDR_W'(off_set(N_PBANK)) ||
            bus_addr == ADDR_W'(off_clr(N_PBANK, N_PBANK))) begin
            bus_rdata = {{PAD_W{1'b0}}, en_b};
        end
        for (int g = 0; g < N_PBANK; g++) begin
            if (bus_addr == ADDR_W'(off_pend(g))) begin
                bus_rdata = pend_p[g*DATA_W +: DATA_W];
            end
            if (bus_addr == ADDR_W'(off_set(g)) ||
                bus_addr == ADDR_W'(off_clr(N_PBANK, g))) begin
                bus_rdata = en_p[g*DATA_W +: DATA_W];
            end
        end
    end

endmodule

// File: rtl/irq_enable_ctrl.sv
// Module: top of the banked interrupt enable controller. Instantiates one
// enable bank per peripheral bank (generate), one basic bank and the register
// decode, and ORs all pending bits into the processor IRQ.
// Assumes sources are already synchronous to clk and level-held until
// serviced.
module irq_enable_ctrl
    import irqc_pkg::*;
#(
    parameter int ADDR_W  = irqc_pkg::ADDR_W,
    parameter int DATA_W  = irqc_pkg::DATA_W,
    parameter int N_PBANK = irqc_pkg::N_PBANK,
    parameter int BASIC_W = irqc_pkg::BASIC_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_PBANK*DATA_W-1:0] periph_irq,
    input  logic [BASIC_W-1:0]        basic_irq,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic                      bus_wr,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    output logic                      irq_out
);

    localparam int NSRC = N_PBANK * DATA_W;

    logic [NSRC-1:0]    en_p;
    logic [NSRC-1:0]    pend_p;
    logic [BASIC_W-1:0] en_b;
    logic [BASIC_W-1:0] pend_b;
    logic [N_PBANK-1:0] set_we_p;
    logic [N_PBANK-1:0] clr_we_p;
    logic               set_we_b;
    logic               clr_we_b;

    irqc_regif #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .N_PBANK(N_PBANK),
        .BASIC_W(BASIC_W)
    ) i_regif (
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .en_p     (en_p),
        .pend_p   (pend_p),
        .en_b     (en_b),
        .pend_b   (pend_b),
        .set_we_p (set_we_p),
        .clr_we_p (clr_we_p),
        .set_we_b (set_we_b),
        .clr_we_b (clr_we_b),
        .bus_rdata(bus_rdata)
    );

    // One enable bank per peripheral bank of DATA_W sources
    for (genvar g = 0; g < N_PBANK; g++) begin : g_pbank
        irqc_bank #(
            .W(DATA_W)
        ) i_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .set_we(set_we_p[g]),
            .clr_we(clr_we_p[g]),
            .wmask (bus_wdata),
            .src   (periph_irq[g*DATA_W +: DATA_W]),
            .en    (en_p[g*DATA_W +: DATA_W]),
            .pend  (pend_p[g*DATA_W +: DATA_W])
        );
    end

    // Basic bank takes only the low BASIC_W bits of the write data
    irqc_bank #(
        .W(BASIC_W)
    ) i_basic (
        .clk   (clk),
        .rst_n (rst_n),
        .set_we(set_we_b),
        .clr_we(clr_we_b),
        .wmask (bus_wdata[BASIC_W-1:0]),
        .src   (basic_irq),
        .en    (en_b),
        .pend  (pend_b)
    );

    // Processor request: any enabled source asserted, in any bank
    always_comb begin
        irq_out = (|pend_p) | (|pend_b);
    end

endmodule

// File: rtl/irqc_checker.sv
// Module: property checker for irq_enable_ctrl, attached with bind.
// Watches the bus, the sources, the enable masks held in the banks, and the
// outputs.
module irqc_checker
    import irqc_pkg::*;
#(
    parameter int ADDR_W  = irqc_pkg::ADDR_W,
    parameter int DATA_W  = irqc_pkg::DATA_W,
    parameter int N_PBANK = irqc_pkg::N_PBANK,
    parameter int BASIC_W = irqc_pkg::BASIC_W
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [N_PBANK*DATA_W-1:0] periph_irq,
    input logic [BASIC_W-1:0]        basic_irq,
    input logic [ADDR_W-1:0]         bus_addr,
    input logic                      bus_wr,
    input logic [DATA_W-1:0]         bus_wdata,
    input logic [DATA_W-1:0]         bus_rdata,
    input logic                      irq_out,
    input logic [N_PBANK*DATA_W-1:0] en_p,
    input logic [BASIC_W-1:0]        en_b
);

    logic wr_pend;
    assign wr_pend = bus_wr && (bus_addr == ADDR_W'(OFF_PEND_BASIC) ||
                                bus_addr == ADDR_W'(off_pend(0)) ||
                                bus_addr == ADDR_W'(off_pend(N_PBANK - 1)));

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (en_p == '0 && en_b == '0 && !irq_out));

    assert_set_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(off_set(0))) |=>
        ((en_p[DATA_W-1:0] & $past(bus_wdata)) == $past(bus_wdata)));

    assert_clr_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(off_clr(N_PBANK, N_PBANK - 1))) |=>
        ((en_p[N_PBANK*DATA_W-1 -: DATA_W] & $past(bus_wdata)) == '0));

    assert_irq_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == ((|(periph_irq & en_p)) || (|(basic_irq & en_b))));

    assert_read_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(off_clr(N_PBANK, N_PBANK))) |->
        (bus_rdata == {{(DATA_W-BASIC_W){1'b0}}, en_b}));

    assert_pend_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pend |=> ($stable(en_p) && $stable(en_b)));

    assert_basic_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFF_PEND_BASIC)) |->
        (bus_rdata[DATA_W-1:BASIC_W] == '0));

endmodule

bind irq_enable_ctrl irqc_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .N_PBANK(N_PBANK),
    .BASIC_W(BASIC_W)
) i_irqc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .periph_irq(periph_irq),
    .basic_irq (basic_irq),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .en_p      (en_p),
    .en_b      (en_b)
);

// File: tb/test_irq_enable_ctrl.sv
// Directed bench for irq_enable_ctrl: one task per scenario, each checking
// its own results. Inputs change at the falling edge; outputs are sampled
// 1 ns after a falling edge.
module test_irq_enable_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] periph_irq = '0;
    logic [7:0]  basic_irq = '0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    irq_enable_ctrl i_irq_enable_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .periph_irq(periph_irq),
        .basic_irq (basic_irq),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    // Compare one value and count the result
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One-cycle register write, ending at a falling edge with the strobe low
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    // Read an offset and compare
    task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic t_reset;
        periph_irq = '1;
        basic_irq  = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd_chk("R1 pend bank1 after reset", 12'h204, 32'h0);
        rd_chk("R1 pend bank2 after reset", 12'h208, 32'h0);
        rd_chk("R1 pend basic after reset", 12'h200, 32'h0);
        rd_chk("R1 enable bank1 after reset", 12'h210, 32'h0);
        rd_chk("R1 enable basic after reset", 12'h218, 32'h0);
        chk("R1 irq low after reset", {31'b0, irq_out}, 32'h0);
        periph_irq = '0;
        basic_irq  = '0;
    endtask

    task automatic t_set;
        wr(12'h210, 32'h0000_000F);
        wr(12'h210, 32'h0000_0100);
        rd_chk("R2 bank1 set accumulates", 12'h210, 32'h0000_010F);
        wr(12'h214, 32'h8000_0001);
        rd_chk("R2 bank2 set", 12'h214, 32'h8000_0001);
        rd_chk("R6 bank2 mask at clear offset", 12'h220, 32'h8000_0001);
        rd_chk("R6 bank1 mask at clear offset", 12'h21C, 32'h0000_010F);
    endtask

    task automatic t_clear;
        wr(12'h21C, 32'h0000_0003);
        rd_chk("R3 bank1 clear selected bits", 12'h210, 32'h0000_010C);
        wr(12'h220, 32'h0000_0001);
        rd_chk("R3 bank2 clear selected bits", 12'h214, 32'h8000_0000);
    endtask

    task automatic t_pending;
        periph_irq = 64'h8000_0000_0000_0105;
        rd_chk("R4 pend bank1 gated", 12'h204, 32'h0000_0104);
        rd_chk("R4 pend bank2 gated", 12'h208, 32'h8000_0000);
        wr(12'h218, 32'hFFFF_FF05);
        rd_chk("R8 basic enable upper bits dropped", 12'h218, 32'h0000_0005);
        basic_irq = 8'hFF;
        rd_chk("R4 R8 pend basic gated", 12'h200, 32'h0000_0005);
    endtask

    task automatic t_irq_level;
        #1;
        chk("R5 irq high with enabled sources", {31'b0, irq_out}, 32'h1);
        periph_irq = '0;
        basic_irq  = '0;
        #1;
        chk("R5 irq drops with sources, same cycle", {31'b0, irq_out}, 32'h0);
        basic_irq = 8'h04;
        #1;
        chk("R5 irq from basic enabled bit", {31'b0, irq_out}, 32'h1);
        basic_irq = 8'h02;
        periph_irq = 64'h0000_0001_0000_0001;
        #1;
        chk("R5 irq low for disabled sources only", {31'b0, irq_out}, 32'h0);
        basic_irq  = '0;
        periph_irq = '0;
    endtask

    task automatic t_ignored;
        wr(12'h200, 32'hFFFF_FFFF);
        wr(12'h204, 32'hFFFF_FFFF);
        wr(12'h208, 32'hFFFF_FFFF);
        wr(12'h20C, 32'hFFFF_FFFF);
        wr(12'h300, 32'hFFFF_FFFF);
        rd_chk("R7 bank1 enables untouched", 12'h210, 32'h0000_010C);
        rd_chk("R7 bank2 enables untouched", 12'h214, 32'h8000_0000);
        rd_chk("R7 basic enables untouched", 12'h218, 32'h0000_0005);
        rd_chk("R9 unmapped read zero", 12'h20C, 32'h0);
        rd_chk("R9 unmapped read zero high", 12'h300, 32'h0);
    endtask

    task automatic t_same_cycle;
        wr(12'h21C, 32'hFFFF_FFFF);
        wr(12'h220, 32'hFFFF_FFFF);
        wr(12'h224, 32'hFFFF_FFFF);
        rd_chk("R3 all bank2 cleared", 12'h214, 32'h0);
        @(negedge clk);
        periph_irq[40] = 1'b1;
        bus_addr  = 12'h214;
        bus_wdata = 32'h0000_0100;
        bus_wr    = 1'b1;
        #1;
        chk("R10 irq still low in write cycle", {31'b0, irq_out}, 32'h0);
        chk("R10 mask old in write cycle", bus_rdata, 32'h0);
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
        chk("R10 irq high after edge", {31'b0, irq_out}, 32'h1);
        chk("R10 mask new after edge", bus_rdata, 32'h0000_0100);
        bus_addr  = 12'h220;
        bus_wdata = 32'h0000_0100;
        bus_wr    = 1'b1;
        #1;
        chk("R10 irq held during clear write", {31'b0, irq_out}, 32'h1);
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
        chk("R10 irq low after clear edge", {31'b0, irq_out}, 32'h0);
        periph_irq = '0;
    endtask

    initial begin
        t_reset();
        t_set();
        t_clear();
        t_pending();
        t_irq_level();
        t_ignored();
        t_same_cycle();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule